// File: doc/BRIEF.md
# Configurable Product-Term Logic Block

This block is one logic tile of a small programmable-logic fabric. A vector of routed input signals enters the tile. For each signal the tile makes a true literal and an inverted literal. A configuration image decides which literals join each AND term. Most of the AND terms are general-purpose. Each macrocell ORs its own consecutive group of them into a sum. The cell then presents that sum either directly or through a register.

A small set of dedicated terms is shared across the tile. Four of them drive the output enables, one sets every cell register asynchronously, one clears every cell register asynchronously, and one supplies the register clock. Each shared term has its own polarity bit, so a single AND pass can also produce an OR of inverted literals.

The configuration image enters one bit at a time on a dedicated configuration clock. The tile stays quiet until the whole image has arrived.

Top module: `plb_logic_block`

## Requirements
- R1: Literal 2*i is input i and literal 2*i+1 is its inverse. A term is the AND of its selected literals, and a term that selects no literal evaluates to 1.
- R2: A term whose disable bit is set evaluates to 0, whatever literals it selects.
- R3: Cell c ORs general terms c*PPC through c*PPC+PPC-1. When its mode bit is 1 the cell outputs that sum directly; when the bit is 0 it outputs its register.
- R4: Every cell register loads its sum on a rising edge of the clock term, taken after its polarity bit is applied.
- R5: While the clear term is active, every cell register reads 0. Clear wins over set when both are active.
- R6: While the set term is active and the clear term is not, every cell register reads 1.
- R7: Cells in the upper half (index N_CELL/2 and above) take their output enable from enable term 0 (select bit 0) or enable term 1 (select bit 1). Cells in the lower half use enable term 2 (select bit 0) or enable term 3 (select bit 1).
- R8: The enable, set, clear and clock terms are each inverted when their polarity bit is 1.
- R9: Configuration bits shift in on rising cfg_clk edges while cfg_en is high, first bit to image bit 0. Term k occupies bits k*(2*N_IN+1) upward: its literal mask comes first, then its disable bit. Terms are ordered as the general terms, then enable terms 0 to 3, then set, clear and clock. After the terms come seven polarity bits in that same control order. Last come two bits per cell: the mode bit, then the enable select.
- R10: cfg_done rises after exactly the full image length has been received. Bits presented after that are ignored until rst_n is asserted.
- R11: Until cfg_done is high, every cell output and output enable is 0 and every cell register is held clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset of the configuration loader |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_en | input | 1 | Shift enable for configuration bits |
| cfg_din | input | 1 | Serial configuration data |
| cfg_done | output | 1 | High once the full image has been received |
| pin_i | input | N_IN | Routed input signals |
| mc_o | output | N_CELL | Macrocell outputs |
| oe_o | output | N_CELL | Per-cell output enables |

## Verification
The bench builds the tile with four inputs, four cells and two general terms per cell. This gives an image of 150 bits, so the bench can load it several times in one run. With only four inputs, random stimulus reaches every literal combination, including the case where the shared set and clear terms fire together. Each half of the cell range holds two cells, so every enable choice in both halves is exercised. Input 0 is used only by the clock term. This lets the bench toggle the register clock without ever changing the data at the same instant, and it lets the bench check both clock polarities.

// File: rtl/plb_pkg.sv
package plb_pkg;
  // Shared control terms, in configuration order
  localparam int N_CTRL = 7;
  localparam int CT_OE0 = 0;
  localparam int CT_OE1 = 1;
  localparam int CT_OE2 = 2;
  localparam int CT_OE3 = 3;
  localparam int CT_SET = 4;
  localparam int CT_RST = 5;
  localparam int CT_CLK = 6;

  // Bits one product term takes in the image: literal mask plus disable
  function automatic int term_bits(input int n_in);
    return 2 * n_in + 1;
  endfunction
endpackage

// File: rtl/plb_cfg_chain.sv
module plb_cfg_chain #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         cfg_clk,
  input  logic         rst_n,
  input  logic         shift_en_i,
  input  logic         bit_i,
  output logic [W-1:0] cfg_q,
  output logic         done_o
);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [CW-1:0] cnt;
  logic          take_bit;

  assign done_o   = (cnt == FULL);
  assign take_bit = shift_en_i & ~done_o;

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      cfg_q <= '0;
    end else if (take_bit) begin
      cfg_q <= {bit_i, cfg_q[W-1:1]};
      cnt   <= cnt + 1'b1;
    end
  end

  AST_DONE_STICKY: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    done_o |=> done_o);                                      // R10
  AST_CFG_FROZEN: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    done_o |=> $stable(cfg_q));                              // R10
  AST_IDLE_HOLD: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !shift_en_i |=> $stable(cfg_q));                         // R9
endmodule

// File: rtl/plb_pterm_array.sv
module plb_pterm_array #(
  parameter int N_IN = 36,
  parameter int N_PT = 87,
  localparam int N_LIT = 2 * N_IN,
  localparam int PT_W = N_LIT + 1
) (
  input  logic [N_IN-1:0]      pin_i,
  input  logic [N_PT*PT_W-1:0] term_cfg_i,
  output logic [N_PT-1:0]      pt_o
);
  logic [N_LIT-1:0] lit;

  // Unselected literals pass as 1; a disabled term is forced low
  function automatic logic and_term(input logic [N_LIT-1:0] l,
                                    input logic [N_LIT-1:0] m,
                                    input logic dis);
    return ~dis & (&(l | ~m));
  endfunction

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   = pin_i[i];
    assign lit[2*i+1] = ~pin_i[i];
  end

  for (genvar k = 0; k < N_PT; k++) begin : g_term
    assign pt_o[k] = and_term(lit, term_cfg_i[k*PT_W +: N_LIT],
                              term_cfg_i[k*PT_W + N_LIT]);
  end
endmodule

// File: rtl/plb_macrocell.sv
module plb_macrocell #(
  parameter int PPC = 5
) (
  input  logic           pclk_i,
  input  logic           arst_i,
  input  logic           aset_i,
  input  logic [PPC-1:0] pt_i,
  input  logic           comb_sel_i,
  output logic           q_o,
  output logic           out_o
);
  logic sum;

  assign sum = |pt_i;

  always_ff @(posedge pclk_i or posedge arst_i or posedge aset_i) begin
    if (arst_i)      q_o <= 1'b0;
    else if (aset_i) q_o <= 1'b1;
    else             q_o <= sum;
  end

  assign out_o = comb_sel_i ? sum : q_o;
endmodule

// File: rtl/plb_logic_block.sv
module plb_logic_block
  import plb_pkg::*;
#(
  parameter int N_IN   = 36,
  parameter int N_CELL = 16,
  parameter int PPC    = 5
) (
  input  logic              rst_n,
  input  logic              cfg_clk,
  input  logic              cfg_en,
  input  logic              cfg_din,
  output logic              cfg_done,
  input  logic [N_IN-1:0]   pin_i,
  output logic [N_CELL-1:0] mc_o,
  output logic [N_CELL-1:0] oe_o
);
  localparam int PT_W      = term_bits(N_IN);
  localparam int N_GEN     = N_CELL * PPC;
  localparam int N_PT      = N_GEN + N_CTRL;
  localparam int TERM_BITS = N_PT * PT_W;
  localparam int POL_BASE  = TERM_BITS;
  localparam int CELL_BASE = POL_BASE + N_CTRL;
  localparam int CFG_W     = CELL_BASE + 2 * N_CELL;
  localparam int HALF      = N_CELL / 2;

  logic [CFG_W-1:0]  cfg;
  logic [N_PT-1:0]   pt;
  logic [N_CTRL-1:0] ctrl;
  logic              ar_eff;
  logic              as_eff;
  logic              pclk;
  logic [N_CELL-1:0] mc_q;
  logic [N_CELL-1:0] mc_raw;

  plb_cfg_chain #(.W(CFG_W)) u_cfg (
    .cfg_clk   (cfg_clk),
    .rst_n     (rst_n),
    .shift_en_i(cfg_en),
    .bit_i     (cfg_din),
    .cfg_q     (cfg),
    .done_o    (cfg_done)
  );

  plb_pterm_array #(.N_IN(N_IN), .N_PT(N_PT)) u_array (
    .pin_i     (pin_i),
    .term_cfg_i(cfg[TERM_BITS-1:0]),
    .pt_o      (pt)
  );

  // Shared control terms after polarity
  for (genvar j = 0; j < N_CTRL; j++) begin : g_ctrl
    assign ctrl[j] = pt[N_GEN + j] ^ cfg[POL_BASE + j];
  end

  // Clear dominates; an unloaded tile is held clear and unclocked
  assign ar_eff = ctrl[CT_RST] | ~cfg_done;
  assign as_eff = ctrl[CT_SET] & ~ar_eff;
  assign pclk   = ctrl[CT_CLK] & cfg_done;

  for (genvar c = 0; c < N_CELL; c++) begin : g_cell
    plb_macrocell #(.PPC(PPC)) u_mc (
      .pclk_i    (pclk),
      .arst_i    (ar_eff),
      .aset_i    (as_eff),
      .pt_i      (pt[c*PPC +: PPC]),
      .comb_sel_i(cfg[CELL_BASE + 2*c]),
      .q_o       (mc_q[c]),
      .out_o     (mc_raw[c])
    );
    assign mc_o[c] = mc_raw[c] & cfg_done;

    if (c >= HALF) begin : g_upper
      assign oe_o[c] = cfg_done &
        (cfg[CELL_BASE + 2*c + 1] ? ctrl[CT_OE1] : ctrl[CT_OE0]);
    end else begin : g_lower
      assign oe_o[c] = cfg_done &
        (cfg[CELL_BASE + 2*c + 1] ? ctrl[CT_OE3] : ctrl[CT_OE2]);
    end
  end

  AST_RESET_WINS: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (cfg_done && ctrl[CT_RST] && ctrl[CT_SET]) |-> (mc_q == '0));   // R5
  AST_SET_FORCES: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (cfg_done && ctrl[CT_SET] && !ctrl[CT_RST]) |-> (&mc_q));       // R6
  AST_IDLE_CLEAR: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !cfg_done |-> (mc_q == '0));                                    // R11
endmodule

// File: tb/plb_logic_block_bench.sv
`timescale 1ns/1ps
module plb_logic_block_bench;
  localparam int NI    = 4;
  localparam int NC    = 4;
  localparam int PP    = 2;
  localparam int NL    = 2 * NI;
  localparam int PTW   = NL + 1;
  localparam int NG    = NC * PP;
  localparam int NT    = NG + 7;
  localparam int POLB  = NT * PTW;
  localparam int CELLB = POLB + 7;
  localparam int W     = CELLB + 2 * NC;

  logic          clk = 1'b0;
  logic          rst_n, cfg_en, cfg_din;
  logic          cfg_done;
  logic [NI-1:0] pin;
  logic [NC-1:0] mc, oe;

  logic [W-1:0]  cfgv;
  logic [NC-1:0] mq;
  logic          prev_ck;
  bit            loaded;
  int            n_chk = 0;
  int            n_fail = 0;

  always #4 clk = ~clk;

  plb_logic_block #(.N_IN(NI), .N_CELL(NC), .PPC(PP)) u_plb_logic_block (
    .rst_n(rst_n), .cfg_clk(clk), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_done(cfg_done), .pin_i(pin), .mc_o(mc), .oe_o(oe)
  );

  function automatic bit tval(int k);
    bit v = 1'b1;
    for (int l = 0; l < NL; l++) begin
      if (cfgv[k*PTW + l]) begin
        if (l % 2 == 0) v = v & pin[l/2];
        else            v = v & !pin[l/2];
      end
    end
    if (cfgv[k*PTW + NL]) v = 1'b0;
    return v;
  endfunction

  function automatic bit cval(int j);
    return tval(NG + j) ^ cfgv[POLB + j];
  endfunction

  function automatic bit sval(int c);
    bit s = 1'b0;
    for (int t = 0; t < PP; t++) s = s | tval(c*PP + t);
    return s;
  endfunction

  function automatic bit oval(int c);
    bit sel = cfgv[CELLB + 2*c + 1];
    if (c >= NC/2) return sel ? cval(1) : cval(0);
    return sel ? cval(3) : cval(2);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(logic [NI-1:0] v, string req);
    logic [NC-1:0] emc, eoe;
    bit ck;
    @(negedge clk);
    pin = v;
    #1;
    if (loaded) begin
      ck = cval(6);
      if (ck && !prev_ck) for (int c = 0; c < NC; c++) mq[c] = sval(c);
      if (cval(5))      mq = '0;
      else if (cval(4)) mq = '1;
      prev_ck = ck;
      for (int c = 0; c < NC; c++) begin
        emc[c] = cfgv[CELLB + 2*c] ? sval(c) : mq[c];
        eoe[c] = oval(c);
      end
    end else begin
      mq = '0; prev_ck = 1'b0; emc = '0; eoe = '0;
    end
    chk({mc, oe} == {emc, eoe}, req, "outputs {mc,oe}",
        int'({mc, oe}), int'({emc, eoe}));
  endtask

  task automatic shift_range(int from, int to);
    for (int i = from; i < to; i++) begin
      @(negedge clk); cfg_en = 1'b1; cfg_din = cfgv[i];
    end
    @(negedge clk); cfg_en = 1'b0;
  endtask

  task automatic shift_junk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cfg_en = 1'b1; cfg_din = 1'b1;
    end
    @(negedge clk); cfg_en = 1'b0; cfg_din = 1'b0;
  endtask

  task automatic build_cfg(bit inv);
    cfgv = '0;
    for (int k = 4; k < NG; k++) begin
      for (int l = 2; l < NL; l++) if ($urandom % 4 == 0) cfgv[k*PTW + l] = 1'b1;
      if ($urandom % 8 == 0) cfgv[k*PTW + NL] = 1'b1;
    end
    cfgv[1*PTW + NL] = 1'b1;                 // term 1 disabled
    cfgv[2*PTW + NL] = 1'b1;                 // term 2 empty but disabled
    cfgv[3*PTW + NL] = 1'b1;
    for (int j = 0; j < 4; j++)
      for (int l = 2; l < NL; l++) if ($urandom % 3 == 0) cfgv[(NG+j)*PTW + l] = 1'b1;
    cfgv[(NG+4)*PTW + 2] = 1'b1;             // set: in1 & in2
    cfgv[(NG+4)*PTW + 4] = 1'b1;
    if (!inv) cfgv[(NG+5)*PTW + 2] = 1'b1;   // clear: in1 & in3, or in3 alone
    cfgv[(NG+5)*PTW + 6] = 1'b1;
    cfgv[(NG+6)*PTW + 0] = 1'b1;             // clock: in0
    for (int j = 0; j < 7; j++) cfgv[POLB + j] = inv;
    for (int c = 0; c < NC; c++) begin
      cfgv[CELLB + 2*c]     = (c < 2);
      cfgv[CELLB + 2*c + 1] = 1'($urandom % 2);
    end
  endtask

  task automatic random_run(int n, string req);
    for (int i = 0; i < n; i++) begin
      step({3'($urandom), pin[0]}, req);
      step({pin[NI-1:1], ~pin[0]}, "R4");
    end
  endtask

  initial begin
    rst_n = 1'b1; cfg_en = 1'b0; cfg_din = 1'b0; pin = '0;
    loaded = 1'b0; mq = '0; prev_ck = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!cfg_done && mc == '0 && oe == '0, "R11", "reset state {done,mc,oe}",
        int'({cfg_done, mc, oe}), 0);

    // Image A: normal polarity, clock rises with in0
    build_cfg(1'b0);
    pin = 4'b0000;
    shift_range(0, W - 1);
    chk(!cfg_done, "R10", "done one bit short", int'(cfg_done), 0);
    step(4'b1110, "R11");
    step(4'b0000, "R11");
    shift_range(W - 1, W);
    chk(cfg_done, "R10", "done after full image", int'(cfg_done), 1);
    loaded = 1'b1; prev_ck = cval(6);
    step(4'b0100, "R9");
    chk(mc[0] == 1'b1, "R1", "empty term drives cell 0", int'(mc[0]), 1);
    chk(mc[1] == 1'b0, "R2", "disabled terms on cell 1", int'(mc[1]), 0);
    shift_junk(16);
    chk(cfg_done, "R10", "done stays after extra bits", int'(cfg_done), 1);
    random_run(40, "R10");
    random_run(40, "R3 R7");
    step(4'b1110, "R5");
    chk(mc[3:2] == 2'b00, "R5", "clear beats set", int'(mc[3:2]), 0);
    step(4'b0110, "R6");
    chk(mc[3:2] == 2'b11, "R6", "set alone", int'(mc[3:2]), 3);
    step(4'b0000, "R6");
    step(4'b0001, "R4");

    // Image B: every control term inverted, clock rises when in0 falls
    @(negedge clk);
    pin = 4'b0001;
    rst_n = 1'b0; loaded = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(4'b0001, "R11");
    build_cfg(1'b1);
    shift_range(0, W);
    chk(cfg_done, "R10", "done after reload", int'(cfg_done), 1);
    loaded = 1'b1; prev_ck = cval(6);
    step(4'b0111, "R8");
    chk(mc[3:2] == 2'b00, "R8", "inverted clear active", int'(mc[3:2]), 0);
    step(4'b1001, "R8");
    chk(mc[3:2] == 2'b11, "R8", "inverted set active", int'(mc[3:2]), 3);
    random_run(60, "R8 R3 R7");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R9: watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule